// File: doc/BRIEF.md
# I2C Memory Slave Protocol Engine

This block is the bus-facing half of a serial nonvolatile memory. It watches the two wires of an I2C bus as a slave only and works out START and STOP from them. It accepts a control byte that names one of two storage regions and carries three chip-enable bits. For a write it takes a two-byte address and then any number of data bytes. For a read it streams bytes back, most significant bit first, for as long as the master keeps acknowledging.

The storage itself sits on the other side of a plain pulse interface. The engine emits one pulse to load the address pointer, one pulse per received data byte, a commit pulse when the write ends, and a fetch request for each byte it is about to transmit. It never drives SDA high. It only asserts an open-drain pull-down enable. While the storage reports that an internal write is running, the engine leaves every control byte unacknowledged, so the master can poll until the write completes.

Top module: `i2c_mem_slave`

## Requirements
- R1: After reset `sda_oe` is 0, `acc_sec` is 0, and no request pulse (`addr_load`, `wdata_push`, `wr_commit`, `rdata_req`) is asserted.
- R2: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high, both judged on the synchronized lines. A START in the middle of a byte restarts control-byte reception. A STOP in the middle of a byte returns the engine to idle.
- R3: `sda_oe` changes only while the synchronized SCL is low, or as a direct response to START or STOP.
- R4: A control byte is acknowledged only when its upper nibble is 4'b1010 or 4'b1011. 4'b1010 sets `acc_sec` to 0 (main array) and 4'b1011 sets it to 1 (security register). Any other nibble is left unacknowledged.
- R5: Control-byte bits [3:1] must equal `dev_sel[2:0]`. On a mismatch the byte is not acknowledged, and the engine ignores the bus and issues no request until the next START.
- R6: While `wr_busy` is 1, no control byte is acknowledged. Once `wr_busy` returns to 0, a matching control byte is acknowledged again.
- R7: Control bit 0 selects the direction (0 = write, 1 = read). In a write, both address bytes are acknowledged. After the second one, `addr_load` pulses with `addr_val` equal to the low 15 bits of {high byte, low byte}, so bit 7 of the high byte is ignored.
- R8: Every data byte after the address is acknowledged and produces one `wdata_push` pulse carrying that byte.
- R9: A STOP that follows at least one data byte pulses `wr_commit` exactly once, including a STOP that arrives mid-byte. A STOP with no data byte, or a repeated START, produces no commit.
- R10: A read control byte is acknowledged and raises `rdata_req`. The engine samples `rdata` one clock after each `rdata_req` and sends that byte MSB first, starting on the SCL low phase that follows the acknowledge clock.
- R11: If the master acknowledges a read byte, the engine raises `rdata_req` and sends another byte. If the master does not acknowledge, the engine releases SDA and requests nothing more.
- R12: The four request pulses never coincide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw bus clock line |
| sda_i | input | 1 | Raw bus data line (resolved wired-AND level) |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| dev_sel | input | 3 | Chip-enable strap levels |
| wr_busy | input | 1 | Storage is running an internal write |
| acc_sec | output | 1 | Region of the current access: 0 main, 1 security |
| addr_load | output | 1 | Pulse: load pointer from `addr_val` |
| addr_val | output | ADDR_W | Address received in a write |
| wdata_push | output | 1 | Pulse: `wdata` holds a received data byte |
| wdata | output | 8 | Received data byte |
| wr_commit | output | 1 | Pulse: start the internal write |
| rdata_req | output | 1 | Pulse: fetch the byte at the pointer and advance |
| rdata | input | 8 | Fetched byte, valid one clock after `rdata_req` |

## Verification
Two functions can fall on the same edge. A STOP can close a transfer at the moment a data byte is only partly shifted in, and this has to commit the bytes already pushed while discarding the partial one. A START can also cut into a partly received control byte. The bench provokes both by issuing a few bit clocks and then the condition. It then judges the commit count, the pushed-byte queue and the acknowledge of the next control byte against its own model of the memory and pointer.

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave #(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [2:0]        dev_sel,
  input  logic              wr_busy,
  output logic              acc_sec,
  output logic              addr_load,
  output logic [ADDR_W-1:0] addr_val,
  output logic              wdata_push,
  output logic [7:0]        wdata,
  output logic              wr_commit,
  output logic              rdata_req,
  input  logic [7:0]        rdata
);

  localparam logic [3:0] CODE_MAIN = 4'b1010;
  localparam logic [3:0] CODE_SEC  = 4'b1011;

  typedef enum logic [2:0] {S_IDLE, S_CTRL, S_AHI, S_ALO, S_WDAT, S_RDAT} st_t;
  st_t st;

  logic [1:0] scl_ff, sda_ff;
  logic       scl_q, sda_q;
  logic [3:0] bitcnt;
  logic       ackph, ack_go, mack, wr_pend, rd_pend;
  logic [7:0] sh, ahi, tx;

  wire scl_s    = scl_ff[1];
  wire sda_s    = sda_ff[1];
  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;
  wire start_c  = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_c   = scl_s & scl_q & ~sda_q & sda_s;

  wire byte_end = scl_fall && bitcnt == 4'd8 && !ackph && st != S_RDAT && st != S_IDLE;
  wire ctrl_ok  = (sh[7:4] == CODE_MAIN || sh[7:4] == CODE_SEC) && sh[3:1] == dev_sel && !wr_busy;
  wire [ADDR_W-1:0] addr_full = ADDR_W'({ahi, sh});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= 2'b11;
      sda_ff <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[0], scl_i};
      sda_ff <= {sda_ff[0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      bitcnt <= '0;
      ackph <= 1'b0;
      ack_go <= 1'b0;
      mack <= 1'b0;
      wr_pend <= 1'b0;
      rd_pend <= 1'b0;
      sh <= '0;
      ahi <= '0;
      tx <= '0;
      sda_oe <= 1'b0;
      acc_sec <= 1'b0;
      addr_load <= 1'b0;
      addr_val <= '0;
      wdata_push <= 1'b0;
      wdata <= '0;
      wr_commit <= 1'b0;
      rdata_req <= 1'b0;
    end else begin
      addr_load  <= 1'b0;
      wdata_push <= 1'b0;
      wr_commit  <= 1'b0;
      rdata_req  <= 1'b0;
      rd_pend    <= rdata_req;
      if (rd_pend) tx <= rdata;

      if (start_c) begin
        st <= S_CTRL;
        bitcnt <= '0;
        ackph <= 1'b0;
        sda_oe <= 1'b0;
        wr_pend <= 1'b0;
      end else if (stop_c) begin
        st <= S_IDLE;
        bitcnt <= '0;
        ackph <= 1'b0;
        sda_oe <= 1'b0;
        wr_commit <= wr_pend;
        wr_pend <= 1'b0;
      end else if (st == S_RDAT) begin
        if (scl_rise && bitcnt != 4'd9) begin
          bitcnt <= bitcnt + 4'd1;
          if (bitcnt == 4'd8) begin
            mack <= ~sda_s;
            rdata_req <= ~sda_s;
          end
        end
        if (scl_fall) begin
          if (bitcnt == 4'd9) begin
            if (mack) begin
              bitcnt <= '0;
              sda_oe <= ~tx[7];
            end else begin
              st <= S_IDLE;
              sda_oe <= 1'b0;
            end
          end else if (bitcnt == 4'd8) begin
            sda_oe <= 1'b0;
          end else begin
            sda_oe <= ~tx[3'd7 - bitcnt[2:0]];
          end
        end
      end else if (st != S_IDLE) begin
        if (scl_rise && bitcnt < 4'd8) begin
          sh <= {sh[6:0], sda_s};
          bitcnt <= bitcnt + 4'd1;
        end
        if (byte_end) begin
          ackph <= 1'b1;
          case (st)
            S_CTRL: begin
              ack_go <= ctrl_ok;
              sda_oe <= ctrl_ok;
              if (ctrl_ok) begin
                acc_sec <= sh[4];
                rdata_req <= sh[0];
              end
            end
            S_AHI: begin
              ack_go <= 1'b1;
              sda_oe <= 1'b1;
              ahi <= sh;
            end
            S_ALO: begin
              ack_go <= 1'b1;
              sda_oe <= 1'b1;
              addr_load <= 1'b1;
              addr_val <= addr_full;
            end
            default: begin
              ack_go <= 1'b1;
              sda_oe <= 1'b1;
              wdata_push <= 1'b1;
              wdata <= sh;
              wr_pend <= 1'b1;
            end
          endcase
        end else if (scl_fall && ackph) begin
          ackph <= 1'b0;
          bitcnt <= '0;
          sda_oe <= 1'b0;
          if (!ack_go) begin
            st <= S_IDLE;
          end else begin
            case (st)
              S_CTRL: begin
                if (sh[0]) begin
                  st <= S_RDAT;
                  sda_oe <= ~tx[7];
                end else begin
                  st <= S_AHI;
                end
              end
              S_AHI:   st <= S_ALO;
              default: st <= S_WDAT;
            endcase
          end
        end
      end
    end
  end

  // R12
  req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({addr_load, wdata_push, wr_commit, rdata_req}));

  // R9
  commit_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> $past(wr_pend));

  // R3
  sda_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(scl_s) && !$past(start_c) && !$past(stop_c)) |-> $stable(sda_oe));

  // R6
  busy_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_end && st == S_CTRL && wr_busy) |=> !sda_oe);

  // R10
  rd_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata_req && st == S_CTRL) |-> sda_oe);

endmodule

// File: tb/i2c_mem_slave_test.sv
module i2c_mem_slave_test;
  localparam int Q = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic scl = 1'b1, sda_d = 1'b1, wr_busy = 1'b0;
  logic [2:0] dev_sel = 3'b101;
  logic [7:0] rdata = '0;
  logic sda_oe, acc_sec, addr_load, wdata_push, wr_commit, rdata_req;
  logic [14:0] addr_val;
  logic [7:0] wdata;
  wire sda_bus = sda_d & ~sda_oe;

  i2c_mem_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .dev_sel(dev_sel), .wr_busy(wr_busy), .acc_sec(acc_sec),
    .addr_load(addr_load), .addr_val(addr_val), .wdata_push(wdata_push),
    .wdata(wdata), .wr_commit(wr_commit), .rdata_req(rdata_req), .rdata(rdata)
  );

  int nchk = 0, nfail = 0;
  int ptr = 0, n_addr = 0, n_commit = 0, n_rdreq = 0, hi_cnt = 0;
  logic [14:0] last_addr = '0;
  logic prev_oe = 1'b0;
  logic [7:0] q[$];
  bit ended = 0;

  function automatic logic [7:0] pat(bit s, int a);
    return s ? 8'((a * 3) + 64) : 8'(a ^ 'hC3);
  endfunction

  task automatic chk(bit ok, string r, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (addr_load) begin ptr <= addr_val; last_addr <= addr_val; n_addr <= n_addr + 1; end
    if (wdata_push) q.push_back(wdata);
    if (wr_commit) n_commit <= n_commit + 1;
    if (rdata_req) begin rdata <= pat(acc_sec, ptr); ptr <= ptr + 1; n_rdreq <= n_rdreq + 1; end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (addr_load | wdata_push | wr_commit | rdata_req)
        chk($countones({addr_load, wdata_push, wr_commit, rdata_req}) == 1, "R12",
            $countones({addr_load, wdata_push, wr_commit, rdata_req}), 1);
      if (sda_oe != prev_oe)
        chk(!(scl && hi_cnt > 4), "R3", hi_cnt, 0);
    end
    prev_oe = sda_oe;
    hi_cnt = scl ? hi_cnt + 1 : 0;
  end

  task automatic tk(int n); repeat (n) @(posedge clk); #1; endtask
  task automatic bstart; sda_d = 1; tk(Q); scl = 1; tk(Q); sda_d = 0; tk(Q); scl = 0; tk(Q); endtask
  task automatic bstop; sda_d = 0; tk(Q); scl = 1; tk(Q); sda_d = 1; tk(Q); endtask
  task automatic bits(logic [7:0] b, int n);
    for (int i = 7; i > 7 - n; i--) begin
      tk(Q); sda_d = b[i]; tk(Q); scl = 1; tk(2 * Q); scl = 0;
    end
  endtask
  task automatic wbyte(logic [7:0] b, output bit ack);
    bits(b, 8);
    tk(Q); sda_d = 1; tk(Q); scl = 1; tk(Q); ack = sda_oe; tk(Q); scl = 0;
  endtask
  task automatic rbyte(bit mk, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      tk(Q); sda_d = 1; tk(Q); scl = 1; tk(Q); b[i] = sda_bus; tk(Q); scl = 0;
    end
    tk(Q); sda_d = ~mk; tk(Q); scl = 1; tk(2 * Q); scl = 0; tk(Q); sda_d = 1;
  endtask

  task automatic summary;
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL R1 watchdog actual=timeout expected=finished");
    summary();
  end

  initial begin
    bit a;
    logic [7:0] b;
    tk(3);
    chk(sda_oe == 0 && acc_sec == 0, "R1", {sda_oe, acc_sec}, 0);
    chk(!(addr_load | wdata_push | wr_commit | rdata_req), "R1",
        {addr_load, wdata_push, wr_commit, rdata_req}, 0);
    rst_n = 1; tk(3);

    // main-array write of two bytes, upper address bit set
    bstart; wbyte(8'hAA, a); chk(a, "R4", a, 1);
    wbyte(8'h81, a); chk(a, "R7", a, 1);
    wbyte(8'h23, a); chk(a, "R7", a, 1);
    chk(last_addr == 15'h0123, "R7", last_addr, 15'h0123);
    chk(acc_sec == 0, "R4", acc_sec, 0);
    wbyte(8'h11, a); chk(a, "R8", a, 1);
    wbyte(8'h22, a); chk(a, "R8", a, 1);
    bstop; tk(6);
    chk(q.size() == 2 && q[0] == 8'h11 && q[1] == 8'h22, "R8", q.size(), 2);
    chk(n_commit == 1, "R9", n_commit, 1);

    // enable-bit mismatch
    bstart; wbyte(8'hA2, a); chk(!a, "R5", a, 0);
    wbyte(8'h00, a); chk(!a, "R5", a, 0);
    chk(n_addr == 1, "R5", n_addr, 1);
    bstop;

    // unknown control code
    bstart; wbyte(8'h9A, a); chk(!a, "R4", a, 0); bstop;

    // busy polling
    wr_busy = 1;
    bstart; wbyte(8'hAA, a); chk(!a, "R6", a, 0); bstop;
    wr_busy = 0;
    bstart; wbyte(8'hAA, a); chk(a, "R6", a, 1); bstop; tk(6);
    chk(n_commit == 1, "R9", n_commit, 1);

    // security-register random read, two bytes
    bstart; wbyte(8'hBA, a); chk(a, "R4", a, 1);
    wbyte(8'h00, a); wbyte(8'h05, a);
    chk(last_addr == 15'd5, "R7", last_addr, 5);
    bstart; wbyte(8'hBB, a); chk(a, "R10", a, 1);
    chk(acc_sec == 1, "R4", acc_sec, 1);
    rbyte(1, b); chk(b == pat(1, 5), "R10", b, pat(1, 5));
    rbyte(0, b); chk(b == pat(1, 6), "R11", b, pat(1, 6));
    bstop; tk(6);
    chk(n_rdreq == 2, "R11", n_rdreq, 2);

    // data byte then repeated START: no commit, read from loaded address
    bstart; wbyte(8'hAA, a); wbyte(8'h00, a); wbyte(8'h10, a);
    wbyte(8'h77, a); chk(a, "R8", a, 1);
    bstart; wbyte(8'hAB, a); chk(a, "R10", a, 1);
    rbyte(0, b); chk(b == pat(0, 16), "R10", b, pat(0, 16));
    bstop; tk(6);
    chk(n_commit == 1, "R9", n_commit, 1);
    chk(n_rdreq == 3, "R11", n_rdreq, 3);

    // START mid control byte, then STOP mid data byte
    bstart; bits(8'hAA, 4);
    bstart; wbyte(8'hAA, a); chk(a, "R2", a, 1);
    wbyte(8'h00, a); wbyte(8'h40, a);
    wbyte(8'h5C, a); chk(a, "R8", a, 1);
    bits(8'hFF, 3); tk(Q); bstop; tk(6);
    chk(n_commit == 2, "R9", n_commit, 2);
    chk(q.size() == 4 && q[3] == 8'h5C, "R2", q.size(), 4);
    bstart; wbyte(8'hAA, a); chk(a, "R2", a, 1); bstop; tk(6);
    chk(sda_oe == 0, "R2", sda_oe, 0);

    summary();
  end
endmodule